// File: doc/BRIEF.md
# BCD Calendar Timebase Counter

This block keeps wall-clock time and calendar date as eight packed-BCD fields: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and a century count. A free-running binary prescaler divides a 32.768 kHz enable strobe down to one tick per second. That tick ripples through a chain of BCD field counters. The month length, including February in leap years, is worked out from the current month and year.

Software sets the time through a parallel load port. A single load pulse replaces every field at once and clears the prescaler, so the first second after a load is a full second. An oscillator-stop input freezes the prescaler, which freezes all counting. A frequency-test input brings a 512 Hz square wave out on a dedicated pin and onto the least significant bit of the seconds output. Counting is made safe for the years up to 2100 by treating every year divisible by 4 as a leap year.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00 and century 00. Counting from legal values keeps every field legal packed BCD (one decimal digit per nibble, tens in bits 7:4) within its range: seconds and minutes 00-59, hours 00-23, day 01-07, date 01-31, month 01-12, year 00-99, century 00-39.
- R2: Each second tick advances seconds. A wrap of seconds from 59 to 00 advances minutes, a wrap of minutes from 59 to 00 advances hours, and hours wrap from 23 to 00.
- R3: The prescaler counts only in cycles where the enable input is 1. The seconds field advances on exactly the 2^PRESC_W-th enable (32768 by default) after reset or load. Cycles without the enable change nothing.
- R4: At the end of a day, date wraps to 01 and month advances after date 30 in months 04, 06, 09 and 11, after date 31 in months 01, 03, 05, 07, 08, 10 and 12, and after date 28 in month 02 of a non-leap year.
- R5: A year whose BCD value is divisible by 4, including 00, is a leap year. In such a year, February runs to date 29 before wrapping.
- R6: Day of week advances on every end of day and wraps from 07 to 01.
- R7: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00 and advances the century. Century wraps from 39 to 00.
- R8: While the oscillator-stop input is 1, the prescaler and every field hold their values whatever the enable does. Counting resumes from the held prescaler value.
- R9: While the frequency-test input is 1 and the stop input is 0, the test output and bit 0 of the seconds output both equal prescaler bit TEST_BIT (bit 5, 512 Hz at a 32.768 kHz enable). Otherwise the test output is 0 and seconds bit 0 shows the stored seconds value.
- R10: A load pulse writes all eight load inputs into the fields on the next clock edge and clears the prescaler. A load takes priority over a second tick in the same cycle.
- R11: A date loaded above the last date of its month wraps to 01 and advances the month at the next end of day.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Prescaler enable strobe, nominally 32.768 kHz |
| osc_stop | input | 1 | 1 freezes the prescaler and all counting |
| ftest_en | input | 1 | 1 enables the 512 Hz test output |
| load_en | input | 1 | One-cycle pulse that loads all fields and clears the prescaler |
| ld_sec | input | 8 | Seconds load value, packed BCD |
| ld_min | input | 8 | Minutes load value, packed BCD |
| ld_hour | input | 8 | Hours load value, packed BCD |
| ld_dow | input | 8 | Day-of-week load value, packed BCD |
| ld_date | input | 8 | Date load value, packed BCD |
| ld_month | input | 8 | Month load value, packed BCD |
| ld_year | input | 8 | Year load value, packed BCD |
| ld_cent | input | 8 | Century load value, packed BCD |
| sec_o | output | 8 | Seconds; bit 0 replaced by the test tone in test mode |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| cent_o | output | 8 | Century |
| tone_512_o | output | 1 | 512 Hz test tone |

## Verification
The counting chain is tried with loads set one second before each interesting end of day:
- a 30-day month, a 31-day month, and a common February;
- Februaries of years 24 and 00, which separate the divisible-by-4 rule from a plain non-leap rule and expose a wrong digit test on year 00;
- an out-of-range date, which tells a greater-or-equal wrap from an equality wrap;
- a full new-year and century wrap, plus a plain minute wrap that must leave the date alone.

Counting one enable short of and then exactly at the prescaler length tells an off-by-one divider from a correct one. A load landing in the same cycle as the final enable shows whether load or tick wins. A stop inserted halfway through a second shows whether the prescaler is frozen or reset. The test tone is sampled at enable counts 0, 32, 64 and 96, then with stop and then with test disabled, which separates the tone from the stored seconds bit.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // chained fields, least significant first; day of week sits outside the chain
  localparam int CHAIN_N  = 7;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_CENT = 6;

  // per-field limits, field i at bits [8*i +: 8]
  localparam logic [CHAIN_N*8-1:0] CHAIN_MIN =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [CHAIN_N*8-1:0] CHAIN_MAX =
    {8'h39, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};

  localparam logic [7:0] DOW_MIN = 8'h01;
  localparam logic [7:0] DOW_MAX = 8'h07;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // (10*t + u) mod 4 == 0  <=>  (2*t[0] + u) mod 4 == 0
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [1:0] s;
    s = yr[1:0] + {yr[4], 1'b0};
    return (s == 2'd0);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         halt,
  input  logic         clear,
  output logic [W-1:0] cnt,
  output logic         tick
);

  logic         run;
  logic [W-1:0] cnt_nxt;

  assign run  = cnt_en & ~halt & ~clear;
  assign tick = run & (&cnt);

  always_comb begin
    cnt_nxt = cnt;
    if (clear)    cnt_nxt = '0;
    else if (run) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] max_val,
  output logic [7:0] val,
  output logic       wrap
);

  logic [7:0] val_nxt;

  // greater-or-equal so an out-of-range loaded value still wraps
  assign wrap = inc & (val >= max_val);

  always_comb begin
    val_nxt = val;
    if (load)      val_nxt = load_val;
    else if (wrap) val_nxt = MIN_VAL;
    else if (inc)  val_nxt = bcd_inc(val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= MIN_VAL;
    else        val <= val_nxt;
  end

endmodule

// File: rtl/cal_month_end.sv
module cal_month_end
  import cal_pkg::*;
(
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);

  always_comb begin
    unique case (month)
      8'h02:                      last_date = bcd_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
  import cal_pkg::*;
#(
  parameter int PRESC_W  = 15,
  parameter int TEST_BIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       osc_stop,
  input  logic       ftest_en,
  input  logic       load_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o,
  output logic       tone_512_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // prescaler
  logic [PRESC_W-1:0] presc_cnt;
  logic               sec_tick;

  cal_prescaler #(.W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_s),
    .cnt_en (tick_en),
    .halt   (osc_stop),
    .clear  (load_en),
    .cnt    (presc_cnt),
    .tick   (sec_tick)
  );

  // field chain
  logic [CHAIN_N*8-1:0] ld_chain;
  logic [7:0]           fval [CHAIN_N];
  logic [7:0]           fmax [CHAIN_N];
  logic [CHAIN_N-1:0]   finc;
  logic [CHAIN_N-1:0]   fwrap;
  logic [7:0]           last_date;

  assign ld_chain = {ld_cent, ld_year, ld_month, ld_date, ld_hour, ld_min, ld_sec};

  cal_month_end u_mend (
    .month     (fval[IDX_MON]),
    .year      (fval[IDX_YEAR]),
    .last_date (last_date)
  );

  for (genvar i = 0; i < CHAIN_N; i++) begin : g_field
    if (i == 0) begin : g_head
      assign finc[i] = sec_tick;
    end else begin : g_link
      assign finc[i] = fwrap[i-1];
    end

    if (i == IDX_DATE) begin : g_dyn
      assign fmax[i] = last_date;
    end else begin : g_fix
      assign fmax[i] = CHAIN_MAX[i*8 +: 8];
    end

    cal_bcd_field #(.MIN_VAL(CHAIN_MIN[i*8 +: 8])) u_fld (
      .clk      (clk),
      .rst_n    (rst_s),
      .inc      (finc[i]),
      .load     (load_en),
      .load_val (ld_chain[i*8 +: 8]),
      .max_val  (fmax[i]),
      .val      (fval[i]),
      .wrap     (fwrap[i])
    );
  end

  // day of week advances on every end of day
  logic       day_adv;
  logic [7:0] dow_q;
  logic       dow_wrap;

  assign day_adv = fwrap[IDX_HOUR];

  cal_bcd_field #(.MIN_VAL(DOW_MIN)) u_dow (
    .clk      (clk),
    .rst_n    (rst_s),
    .inc      (day_adv),
    .load     (load_en),
    .load_val (ld_dow),
    .max_val  (DOW_MAX),
    .val      (dow_q),
    .wrap     (dow_wrap)
  );

  // named views for the outputs and the checker
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, year_q, cent_q;
  logic       ft_active;

  assign sec_q   = fval[IDX_SEC];
  assign min_q   = fval[IDX_MIN];
  assign hour_q  = fval[IDX_HOUR];
  assign date_q  = fval[IDX_DATE];
  assign month_q = fval[IDX_MON];
  assign year_q  = fval[IDX_YEAR];
  assign cent_q  = fval[IDX_CENT];

  assign ft_active  = ftest_en & ~osc_stop;
  assign tone_512_o = ft_active & presc_cnt[TEST_BIT];

  assign sec_o   = {sec_q[7:1], ft_active ? presc_cnt[TEST_BIT] : sec_q[0]};
  assign min_o   = min_q;
  assign hour_o  = hour_q;
  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;
  assign cent_o  = cent_q;

endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_stop,
  input logic          load_en,
  input logic          day_adv,
  input logic [PW-1:0] presc,
  input logic [7:0]    last_date,
  input logic [7:0]    ld_sec,
  input logic [7:0]    ld_date,
  input logic [7:0]    sec_q,
  input logic [7:0]    hour_q,
  input logic [7:0]    dow_q,
  input logic [7:0]    date_q,
  input logic [7:0]    year_q,
  input logic [7:0]    cent_q
);

  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] mx);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= mx);
  endfunction

  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && $past(bcd_ok(sec_q, 8'h59))) |-> bcd_ok(sec_q, 8'h59)); // R1

  AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && $past(bcd_ok(hour_q, 8'h23))) |-> bcd_ok(hour_q, 8'h23)); // R2

  AST_DATE_WITHIN_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && !$stable(date_q)) |-> (date_q <= last_date)); // R4

  AST_DOW_ON_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !load_en) |=>
      (dow_q == (($past(dow_q) >= 8'h07) ? 8'h01 : ($past(dow_q) + 8'h01)))); // R6

  AST_CENT_ON_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && $past(year_q) == 8'h99 && year_q == 8'h00) |->
      (cent_q == (($past(cent_q) >= 8'h39) ? 8'h00 :
                  ($past(cent_q[3:0]) == 4'd9) ? {$past(cent_q[7:4]) + 4'd1, 4'd0} :
                  ($past(cent_q) + 8'h01)))); // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load_en) |=> ($stable(presc) && $stable(sec_q) && $stable(date_q))); // R8

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (presc == '0 && sec_q == $past(ld_sec) && date_q == $past(ld_date))); // R10

endmodule

bind bcd_calendar_counter cal_checker #(.PW(PRESC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .osc_stop  (osc_stop),
  .load_en   (load_en),
  .day_adv   (day_adv),
  .presc     (presc_cnt),
  .last_date (last_date),
  .ld_sec    (ld_sec),
  .ld_date   (ld_date),
  .sec_q     (sec_q),
  .hour_q    (hour_q),
  .dow_q     (dow_q),
  .date_q    (date_q),
  .year_q    (year_q),
  .cent_q    (cent_q)
);

// File: tb/tb_bcd_calendar_counter.sv
`timescale 1ns/1ps
module tb_bcd_calendar_counter;

  localparam int PW  = 7;
  localparam int DIV = 1 << PW;

  logic clk, rst_n, tick_en, osc_stop, ftest_en, load_en;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_month, ld_year, ld_cent;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;
  logic       tone_512_o;

  bcd_calendar_counter #(.PRESC_W(PW), .TEST_BIT(5)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string       req;
    bit          kind;   // 0: all fields, 1: {tone, sec bit0}
    logic [63:0] exp;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  function automatic logic [63:0] pk(input logic [7:0] c, y, mo, d, w, h, mi, s);
    return {c, y, mo, d, w, h, mi, s};
  endfunction

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = sb_q.pop_front();
        if (it.kind == 1'b0)
          act = {cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
        else
          act = {62'd0, tone_512_o, sec_o[0]};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input string req, input bit kind, input logic [63:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic set_ld(input logic [7:0] c, y, mo, d, w, h, mi, s);
    ld_cent = c; ld_year = y; ld_month = mo; ld_date = d;
    ld_dow = w; ld_hour = h; ld_min = mi; ld_sec = s;
  endtask

  task automatic load_all(input logic [7:0] c, y, mo, d, w, h, mi, s);
    @(negedge clk);
    set_ld(c, y, mo, d, w, h, mi, s);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_en(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; osc_stop = 1'b0; ftest_en = 1'b0; load_en = 1'b0;
    set_ld(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    expect_item("R1 reset state", 0, pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));

    // R3 no enable, no change
    repeat (50) @(negedge clk);
    expect_item("R3 idle without enable", 0, pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));

    // R3 divider length
    run_en(DIV - 1);
    expect_item("R3 one enable short", 0, pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    run_en(1);
    expect_item("R3 full second", 0, pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01));

    // R10 prescaler cleared by load; R2 R6 R7 full wrap
    load_all(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    expect_item("R10 load all fields", 0, pk(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58));
    run_en(DIV - 1);
    expect_item("R10 prescaler cleared", 0, pk(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58));
    run_en(1);
    expect_item("R2 seconds step", 0, pk(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59));
    run_en(DIV);
    expect_item("R7 century wrap R6 R2", 0, pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));

    // R2 minute wrap only
    load_all(8'h20, 8'h26, 8'h06, 8'h15, 8'h02, 8'h10, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R2 minute into hour", 0, pk(8'h20, 8'h26, 8'h06, 8'h15, 8'h02, 8'h11, 8'h00, 8'h00));

    // R4 common February
    load_all(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R4 Feb 28 common year", 0, pk(8'h20, 8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));

    // R5 leap years
    load_all(8'h20, 8'h24, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R5 year 24 Feb 29", 0, pk(8'h20, 8'h24, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00));
    load_all(8'h20, 8'h24, 8'h02, 8'h29, 8'h06, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R5 leap Feb 29 ends", 0, pk(8'h20, 8'h24, 8'h03, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00));
    load_all(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R5 year 00 leap", 0, pk(8'h20, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00));

    // R4 30- and 31-day months, R6 dow wrap
    load_all(8'h20, 8'h25, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R4 April end R6 dow wrap", 0, pk(8'h20, 8'h25, 8'h05, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    load_all(8'h20, 8'h25, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R4 January end", 0, pk(8'h20, 8'h25, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));

    // R7 new year
    load_all(8'h21, 8'h19, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R7 year step", 0, pk(8'h21, 8'h20, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00));

    // R11 out-of-range date
    load_all(8'h20, 8'h26, 8'h04, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    run_en(DIV);
    expect_item("R11 April 31 wraps", 0, pk(8'h20, 8'h26, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));

    // R10 load beats tick
    load_all(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h00);
    run_en(DIV - 1);
    @(negedge clk);
    set_ld(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h30, 8'h20);
    tick_en = 1'b1; load_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; load_en = 1'b0;
    expect_item("R10 load over tick", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h30, 8'h20));
    run_en(DIV - 1);
    expect_item("R10 fresh second after load", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h30, 8'h20));
    run_en(1);
    expect_item("R10 second after load", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h30, 8'h21));

    // R8 stop freezes prescaler
    load_all(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h10);
    run_en(DIV / 2);
    @(negedge clk);
    osc_stop = 1'b1;
    run_en(2 * DIV);
    expect_item("R8 frozen while stopped", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h10));
    @(negedge clk);
    osc_stop = 1'b0;
    run_en(DIV / 2 - 1);
    expect_item("R8 prescaler held not cleared", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h10));
    run_en(1);
    expect_item("R8 resumes", 0, pk(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h11));

    // R9 test tone
    @(negedge clk);
    ftest_en = 1'b1;
    load_all(8'h20, 8'h30, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h11);
    expect_item("R9 tone low at count 0", 1, 64'd0);
    run_en(32);
    expect_item("R9 tone high at count 32", 1, 64'd3);
    run_en(32);
    expect_item("R9 tone low at count 64", 1, 64'd0);
    run_en(32);
    expect_item("R9 tone high at count 96", 1, 64'd3);
    osc_stop = 1'b1;
    #1;
    expect_item("R9 stopped shows stored bit", 1, 64'd1);
    osc_stop = 1'b0;
    ftest_en = 1'b0;
    #1;
    expect_item("R9 test off shows stored bit", 1, 64'd1);

    #5;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule